// File: doc/BRIEF.md
# Dual-Mode Register Access Window

This block sits on the target side of a simplified host bus, in front of a small internal register file. Each host request carries a four-bit command code, a byte address, four active-low byte enables and a 32-bit data word. The command code chooses one of two paths to the same registers. Memory commands decode the address directly: register `i` sits at `MEM_BASE + 4*i`. I/O commands go through an eight-byte window at `IO_BASE` instead. That window has a data port and a register-select pointer. The pointer keeps its value between accesses, and every data-port access goes to the register the pointer currently names.

Configuration commands and unassigned command codes get no response and change nothing. A read returns its data one cycle after it is accepted, together with a single-cycle valid flag. Writes return nothing. The `ptr_word_only` input models an option strap. When it is high, a pointer write must be a 16-bit access, and a pointer write of any other width is dropped.

Top module: `reg_access_window`

## Requirements
- R1: Memory read commands 0x6, 0xC and 0xE read register `i` at byte address `MEM_BASE + 4*i`. Memory write commands 0x7 and 0xF write register `i` at that address. No pointer is involved in these accesses.
- R2: Bit `k` of `req_be_n` low enables byte lane `k` (data bits `8k+7:8k`). A write updates only the enabled lanes. A read returns zero in every disabled lane.
- R3: The I/O window covers `IO_BASE` to `IO_BASE+7`, with `IO_BASE` aligned to 8 bytes. Address bit 2 low selects the data port and address bit 2 high selects the pointer. An I/O read (0x2) of the pointer returns `{16'h0, pointer}`.
- R4: An I/O write (0x3) to the pointer loads pointer bits 7:0 from lane 0 and bits 15:8 from lane 1, if those lanes are enabled. I/O reads and writes of the data port access register `pointer >> 2`. The pointer never changes on its own, so repeated data-port accesses all reach the same register.
- R5: When `ptr_word_only` is high, a pointer write takes effect only if exactly two adjacent byte enables are active (`req_be_n` = 4'b1100, 4'b1001 or 4'b0011). Any other pointer write leaves the pointer unchanged.
- R6: Configuration commands 0xA and 0xB and every unassigned command code raise no response and change no register or pointer.
- R7: Some accesses fall outside the block's range: a memory address outside `MEM_BASE` to `MEM_BASE+4*NREG-1`, an I/O address outside the window, or a data-port access while `pointer >> 2 >= NREG`. Such a read still responds, with all-zero data. Such a write changes nothing.
- R8: `rsp_valid` is high for exactly one cycle, in the cycle after a read request is accepted. A write never raises it.
- R9: Reset (`rst_n` low) clears every register, the pointer and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_word_only | input | 1 | Requires pointer writes to be 16 bits wide |
| req_valid | input | 1 | Request strobe; the request is taken in this cycle |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Byte address |
| req_be_n | input | 4 | Active-low byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest state to reach is a pointer that names a register beyond the file while the data port is still in use. Reaching it takes a specific order of stimulus: a 16-bit pointer write that loads an out-of-range value, then a data-port write and a data-port read, then a direct read of the last real register to show that nothing leaked. Pointer writes that must be dropped under the width strap are checked the same way. A dropped write is followed by a pointer readback that must still show the old value. The same data port is also written twice without rewriting the pointer, and a direct read then shows that the second write went to the same register.

// File: rtl/reg_access_window.sv
module reg_access_window #(
  parameter int ADDR_W = 16,
  parameter int NREG = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_word_only,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be_n,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NREG);
  localparam logic [15:0] PTR_LIM = 16'(4 * NREG);

  logic [31:0] regs [NREG];
  logic [15:0] ptr;

  logic io_rd, io_wr, m_rd, m_wr;
  assign io_rd = (req_cmd == 4'h2);
  assign io_wr = (req_cmd == 4'h3);
  assign m_rd  = (req_cmd == 4'h6) || (req_cmd == 4'hC) || (req_cmd == 4'hE);
  assign m_wr  = (req_cmd == 4'h7) || (req_cmd == 4'hF);

  logic [ADDR_W-1:0] mem_off;
  logic mem_hit, io_hit, ptr_ok;
  assign mem_off = req_addr - MEM_BASE;
  assign mem_hit = (req_addr >= MEM_BASE) && (mem_off < SPAN);
  assign io_hit  = (req_addr[ADDR_W-1:3] == IO_BASE[ADDR_W-1:3]);
  assign ptr_ok  = (ptr < PTR_LIM);

  logic io_acc, via_io, via_mem, reg_wr, ptr_wr, rd_req, two_adj;
  logic [IDX_W-1:0] idx;
  assign io_acc  = req_valid && (io_rd || io_wr) && io_hit;
  assign via_io  = io_acc && !req_addr[2] && ptr_ok;
  assign via_mem = req_valid && (m_rd || m_wr) && mem_hit;
  assign reg_wr  = (via_io && io_wr) || (via_mem && m_wr);
  assign idx     = via_mem ? mem_off[IDX_W+1:2] : ptr[IDX_W+1:2];
  assign two_adj = (req_be_n == 4'b1100) || (req_be_n == 4'b1001) || (req_be_n == 4'b0011);
  assign ptr_wr  = io_acc && io_wr && req_addr[2] && (!ptr_word_only || two_adj);
  assign rd_req  = req_valid && (io_rd || m_rd);

  logic [31:0] rd_word, lane_mask;
  always_comb begin
    rd_word = 32'h0;
    if (io_acc && req_addr[2]) rd_word = {16'h0, ptr};
    else if (via_io || via_mem) rd_word = regs[idx];
  end
  assign lane_mask = {{8{!req_be_n[3]}}, {8{!req_be_n[2]}}, {8{!req_be_n[1]}}, {8{!req_be_n[0]}}};

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int r = 0; r < NREG; r++) regs[r][8*l +: 8] <= 8'h0;
      end else if (reg_wr && !req_be_n[l]) begin
        regs[idx][8*l +: 8] <= req_wdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= 16'h0;
    end else if (ptr_wr) begin
      if (!req_be_n[0]) ptr[7:0]  <= req_wdata[7:0];
      if (!req_be_n[1]) ptr[15:8] <= req_wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? (rd_word & lane_mask) : 32'h0;
    end
  end

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (io_wr || m_wr) |=> !rsp_valid); // R8
  AST_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_cmd == 4'hA || req_cmd == 4'hB) |=> !rsp_valid); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && io_wr && io_hit && req_addr[2]) |=> $stable(ptr)); // R4
  AST_PTR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ptr_word_only && io_wr && io_hit && req_addr[2] && $countones(~req_be_n) != 2
    |=> $stable(ptr)); // R5
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (io_rd || m_rd) && req_be_n[0] |=> rsp_rdata[7:0] == 8'h0); // R2
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && m_rd && !mem_hit |=> rsp_valid && rsp_rdata == 32'h0); // R7
endmodule

// File: tb/test_reg_access_window.sv
module test_reg_access_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_word_only = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_cmd = 4'h0;
  logic [15:0] req_addr = 16'h0;
  logic [3:0] req_be_n = 4'hF;
  logic [31:0] req_wdata = 32'h0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  reg_access_window i_reg_access_window (
    .clk(clk), .rst_n(rst_n), .ptr_word_only(ptr_word_only),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_be_n(req_be_n), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // {req tag, strap, cmd, addr, be_n, wdata, expect response, expected data}
  localparam int NV = 38;
  localparam logic [93:0] VEC [NV] = '{
    {4'd1, 1'b0, 4'h7, 16'h1000, 4'h0, 32'h11223344, 1'b0, 32'h0},         // R1
    {4'd1, 1'b0, 4'h6, 16'h1000, 4'h0, 32'h0, 1'b1, 32'h11223344},         // R1
    {4'd2, 1'b0, 4'h7, 16'h1008, 4'hE, 32'hAABBCCDD, 1'b0, 32'h0},         // R2
    {4'd2, 1'b0, 4'hE, 16'h1008, 4'h0, 32'h0, 1'b1, 32'h000000DD},         // R2
    {4'd1, 1'b0, 4'hF, 16'h1004, 4'h0, 32'h55667788, 1'b0, 32'h0},         // R1
    {4'd2, 1'b0, 4'hC, 16'h1004, 4'h3, 32'h0, 1'b1, 32'h55660000},         // R2
    {4'd4, 1'b0, 4'h3, 16'h0044, 4'hC, 32'h00000008, 1'b0, 32'h0},         // R4
    {4'd3, 1'b0, 4'h2, 16'h0044, 4'h0, 32'h0, 1'b1, 32'h00000008},         // R3
    {4'd4, 1'b0, 4'h2, 16'h0040, 4'h0, 32'h0, 1'b1, 32'h000000DD},         // R4
    {4'd4, 1'b0, 4'h3, 16'h0040, 4'h0, 32'hCAFEF00D, 1'b0, 32'h0},         // R4
    {4'd4, 1'b0, 4'h6, 16'h1008, 4'h0, 32'h0, 1'b1, 32'hCAFEF00D},         // R4
    {4'd4, 1'b0, 4'h3, 16'h0040, 4'h0, 32'h12345678, 1'b0, 32'h0},         // R4
    {4'd4, 1'b0, 4'h6, 16'h100C, 4'h0, 32'h0, 1'b1, 32'h0},                // R4
    {4'd4, 1'b0, 4'h6, 16'h1008, 4'h0, 32'h0, 1'b1, 32'h12345678},         // R4
    {4'd5, 1'b1, 4'h3, 16'h0044, 4'hE, 32'h00000004, 1'b0, 32'h0},         // R5
    {4'd5, 1'b1, 4'h2, 16'h0044, 4'h0, 32'h0, 1'b1, 32'h00000008},         // R5
    {4'd5, 1'b1, 4'h3, 16'h0044, 4'hC, 32'h0000000C, 1'b0, 32'h0},         // R5
    {4'd5, 1'b1, 4'h2, 16'h0044, 4'h0, 32'h0, 1'b1, 32'h0000000C},         // R5
    {4'd4, 1'b0, 4'h2, 16'h0040, 4'h0, 32'h0, 1'b1, 32'h0},                // R4
    {4'd6, 1'b0, 4'hB, 16'h1000, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},         // R6
    {4'd6, 1'b0, 4'hA, 16'h1000, 4'h0, 32'h0, 1'b0, 32'h0},                // R6
    {4'd6, 1'b0, 4'h6, 16'h1000, 4'h0, 32'h0, 1'b1, 32'h11223344},         // R6
    {4'd7, 1'b0, 4'h7, 16'h1040, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},         // R7
    {4'd7, 1'b0, 4'h6, 16'h1040, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd7, 1'b0, 4'h6, 16'h103C, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd7, 1'b0, 4'h2, 16'h0048, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd7, 1'b0, 4'h3, 16'h0048, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},         // R7
    {4'd7, 1'b0, 4'h2, 16'h0044, 4'h0, 32'h0, 1'b1, 32'h0000000C},         // R7
    {4'd7, 1'b0, 4'h3, 16'h0044, 4'hC, 32'h00000040, 1'b0, 32'h0},         // R7
    {4'd7, 1'b0, 4'h3, 16'h0040, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},         // R7
    {4'd7, 1'b0, 4'h2, 16'h0040, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd7, 1'b0, 4'h6, 16'h103C, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd7, 1'b0, 4'h6, 16'h0040, 4'h0, 32'h0, 1'b1, 32'h0},                // R7
    {4'd4, 1'b0, 4'h3, 16'h0044, 4'hE, 32'h00000004, 1'b0, 32'h0},         // R4
    {4'd3, 1'b0, 4'h2, 16'h0044, 4'h0, 32'h0, 1'b1, 32'h00000004},         // R3
    {4'd4, 1'b0, 4'h2, 16'h0040, 4'h0, 32'h0, 1'b1, 32'h55667788},         // R4
    {4'd6, 1'b0, 4'h5, 16'h1000, 4'h0, 32'hFFFFFFFF, 1'b0, 32'h0},         // R6
    {4'd6, 1'b0, 4'h6, 16'h1000, 4'h0, 32'h0, 1'b1, 32'h11223344}          // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic strap, input logic [3:0] cmd, input logic [15:0] addr,
                     input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    ptr_word_only = strap; req_valid = 1'b1; req_cmd = cmd;
    req_addr = addr; req_be_n = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_be_n = 4'hF; req_wdata = 32'h0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog R8 actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    req(1'b0, 4'h2, 16'h0044, 4'h0, 32'h0);
    check("R9 pointer after reset", rsp_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      req(VEC[v][89], VEC[v][88:85], VEC[v][84:69], VEC[v][68:65], VEC[v][64:33]);
      check($sformatf("R%0d vec %0d valid", VEC[v][93:90], v), {31'h0, rsp_valid}, {31'h0, VEC[v][32]});
      if (VEC[v][32])
        check($sformatf("R%0d vec %0d data", VEC[v][93:90], v), rsp_rdata, VEC[v][31:0]);
    end

    // R8: response lasts one cycle only
    req(1'b0, 4'h6, 16'h1000, 4'h0, 32'h0);
    check("R8 response present", {31'h0, rsp_valid}, 32'h1);
    @(negedge clk);
    check("R8 response gone", {31'h0, rsp_valid}, 32'h0);

    // R9: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    req(1'b0, 4'h6, 16'h1000, 4'h0, 32'h0);
    check("R9 register cleared", rsp_rdata, 32'h0);
    req(1'b0, 4'h2, 16'h0044, 4'h0, 32'h0);
    check("R9 pointer cleared", rsp_rdata, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule